// File: doc/BRIEF.md
# Lockable GPIO Controller with Event Detection

This block is a general-purpose I/O controller with a configurable number of pins behind a simple single-cycle register bus. For every pin it decides, inside the model, what level the pin carries. The inputs to that decision are the output enable, the output data, the pin's drive type (push-pull or open-drain), a per-pin polarity inversion, weak pull-up and pull-down selections, and an input-enable mask. When nothing decides the level, the pin falls back to an external pad input. The resolved level of every pin is brought out, and a data-in word gives software the level as seen through polarity and mask.

Software changes output data, output enable and event enable either by plain writes or by atomic set and clear alias words. A two-word temporary lock freezes the configuration. Once locked, the block opens again only after a fixed pair of key words is written in the right order. Each pin can raise an event on a high level, on a rising edge, or on both edges. Events are recorded in a sticky status word that software clears by writing ones. A single interrupt line combines the status with a per-pin enable.

Top module: `gpio_lockctl`

## Requirements
- R1: After reset the lock is open, the pull-up word and the input-enable word are all ones, every other configuration word (data out, output enable, drive type, polarity, pull-down, event mode, both-edge, event enable) reads zero, and the interrupt is low.
- R2: A pin with its output enable set and drive type 0 (push-pull) carries the driven level, data-out XOR polarity, whatever its pulls are, so that with input enabled data-in equals data-out.
- R3: A pin whose output is not driving, with pull-up differing from pull-down, carries the pull-up value.
- R4: A pin whose output is not driving, with pull-up equal to pull-down, carries the external pad input.
- R5: With drive type 1 (open-drain), a driven level of 0 pulls the pin low and a driven level of 1 leaves the pin to R3 and R4. With output enable clear, the drive type has no effect.
- R6: Data-in bit equals (input-enable AND pin level) XOR polarity, so a masked pin reads its polarity bit.
- R7: Writing the set alias of data-out, output-enable or event-enable ORs the written mask into that word. Writing the clear alias removes the written mask from it.
- R8: Any write to lock word A (index 18) or lock word B (index 19) locks the block, and lock word A then reads 1. The only exception is the unlock sequence: KEY_B (default 0x9A3C5EED) written to word B, followed directly by KEY_A (default 0x4F1D0B7C) written to word A. That sequence unlocks the block and word A reads 0. Any other write between the two key writes cancels the sequence.
- R9: While locked, writes to every configuration word and alias are ignored. Writes that clear event status still take effect.
- R10: An event-mode bit of 0 selects level events. The status bit is set in the cycle after data-in reads 1 and is set again at once if it is cleared while data-in is still 1.
- R11: An event-mode bit of 1 selects edge events on data-in. A 0 to 1 change sets status. A 1 to 0 change also sets status when the both-edge bit is 1.
- R12: Event status is sticky. A bit drops only when a one is written to it in the status word (index 17).
- R13: The interrupt is high exactly when some pin has both status and event enable set. It follows event-enable changes in the cycle after the write, and it stays high while its status is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Register word index (0 data out, 1 data-out set, 2 data-out clear, 3 output enable, 4 enable set, 5 enable clear, 6 drive type, 7 polarity, 8 pull-up, 9 pull-down, 10 input enable, 11 data in, 12 event mode, 13 both-edge, 14 event enable, 15 event-enable set, 16 event-enable clear, 17 event status, 18 lock word A, 19 lock word B) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational, pin fields zero-extended |
| pad_in | input | NPINS | External level for pins that nothing else decides |
| pin_level | output | NPINS | Resolved level of each pin |
| irq | output | 1 | Combined event interrupt |

## Verification
The bench builds the controller with NPINS = 8. With only eight pins it can walk all 256 combinations of output enable, drive type, data-out, polarity, pull-up, pull-down, input enable and pad value, one combination per pin, in 32 register batches. Each batch checks the resolved pin word and the data-in word against the resolution formula. The small width also lets directed sequences cover every lock transition, including a cancelled key sequence, and set, sticky-hold and clear paths for level, rising-edge and both-edge events together with the interrupt mask.

// File: rtl/gpio_lockctl_pkg.sv
package gpio_lockctl_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        IDX_DOUT     = 5'd0,
        IDX_DOUT_SET = 5'd1,
        IDX_DOUT_CLR = 5'd2,
        IDX_OE       = 5'd3,
        IDX_OE_SET   = 5'd4,
        IDX_OE_CLR   = 5'd5,
        IDX_OTYPE    = 5'd6,
        IDX_POL      = 5'd7,
        IDX_PULLUP   = 5'd8,
        IDX_PULLDN   = 5'd9,
        IDX_INEN     = 5'd10,
        IDX_DIN      = 5'd11,
        IDX_EVMODE   = 5'd12,
        IDX_EVBOTH   = 5'd13,
        IDX_EVEN     = 5'd14,
        IDX_EVEN_SET = 5'd15,
        IDX_EVEN_CLR = 5'd16,
        IDX_EVSTAT   = 5'd17,
        IDX_LOCK_A   = 5'd18,
        IDX_LOCK_B   = 5'd19
    } reg_idx_e;

endpackage

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] dout,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] oe,
    input  logic [NPINS-1:0] otype,
    input  logic [NPINS-1:0] pu,
    input  logic [NPINS-1:0] pd,
    input  logic [NPINS-1:0] inen,
    input  logic [NPINS-1:0] pad,
    output logic [NPINS-1:0] pin,
    output logic [NPINS-1:0] din
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic drv_lvl;
        logic drives;
        logic weak_lvl;

        always_comb begin
            drv_lvl  = dout[i] ^ pol[i];
            // open-drain only actively drives a low level
            drives   = oe[i] & (~otype[i] | ~drv_lvl);
            weak_lvl = (pu[i] != pd[i]) ? pu[i] : pad[i];
            pin[i]   = drives ? drv_lvl : weak_lvl;
            din[i]   = (inen[i] & pin[i]) ^ pol[i];
        end
    end

endmodule

// File: rtl/gpio_lock_unit.sv
module gpio_lock_unit #(
    parameter logic [31:0] KEY_A = 32'h4F1D_0B7C,
    parameter logic [31:0] KEY_B = 32'h9A3C_5EED
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_a,
    input  logic        wr_b,
    input  logic        wr_other,
    input  logic [31:0] wdata,
    output logic        locked
);

    typedef struct packed {
        logic locked;
        logic armed;
    } lock_t;

    lock_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_b) begin
            st_d.locked = 1'b1;
            st_d.armed  = (wdata == KEY_B);
        end else if (wr_a) begin
            if (st_q.armed && wdata == KEY_A) begin
                st_d.locked = 1'b0;
            end else begin
                st_d.locked = 1'b1;
            end
            st_d.armed = 1'b0;
        end else if (wr_other) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

    // R8: a non-key write to word B always leaves the block locked
    a_r8_lock_b_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && wdata != KEY_B) |=> locked);

    // R8: unlocking needs the armed state reached by the previous write
    a_r8_unlock_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !st_q.armed) |=> locked);

endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] din,
    input  logic [NPINS-1:0] edge_sel,
    input  logic [NPINS-1:0] both_sel,
    input  logic             clr_en,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] status
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] stat;
    } ev_t;

    ev_t ev_q, ev_d;
    logic [NPINS-1:0] rise, fall, hit, clr;

    always_comb begin
        rise = din & ~ev_q.prev;
        fall = ~din & ev_q.prev;
        hit  = (~edge_sel & din) | (edge_sel & (rise | (both_sel & fall)));
        clr  = clr_en ? clr_mask : '0;
        ev_d.prev = din;
        ev_d.stat = (ev_q.stat & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign status = ev_q.stat;

    // R12: without a clear write no status bit drops
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((status & $past(status)) == $past(status)));

    // R10: a high level-mode input is recorded in the next cycle
    a_r10_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|(din & ~edge_sel)) |=> ((status & $past(din & ~edge_sel)) == $past(din & ~edge_sel)));

endmodule

// File: rtl/gpio_lockctl.sv
module gpio_lockctl
    import gpio_lockctl_pkg::*;
#(
    parameter int          NPINS = 32,
    parameter logic [31:0] KEY_A = 32'h4F1D_0B7C,
    parameter logic [31:0] KEY_B = 32'h9A3C_5EED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pin_level,
    output logic              irq
);

    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] oe;
        logic [NPINS-1:0] otype;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] pu;
        logic [NPINS-1:0] pd;
        logic [NPINS-1:0] inen;
        logic [NPINS-1:0] evmode;
        logic [NPINS-1:0] evboth;
        logic [NPINS-1:0] even;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    reg_idx_e         idx;
    logic [NPINS-1:0] wmask;
    logic [NPINS-1:0] din;
    logic [NPINS-1:0] status;
    logic             locked;
    logic             wr_a, wr_b, wr_other, clr_en;

    assign idx      = reg_idx_e'(bus_addr);
    assign wmask    = bus_wdata[NPINS-1:0];
    assign wr_a     = bus_wr && idx == IDX_LOCK_A;
    assign wr_b     = bus_wr && idx == IDX_LOCK_B;
    assign wr_other = bus_wr && !wr_a && !wr_b;
    assign clr_en   = bus_wr && idx == IDX_EVSTAT;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr && !locked) begin
            case (idx)
                IDX_DOUT:     cfg_d.dout   = wmask;
                IDX_DOUT_SET: cfg_d.dout   = cfg_q.dout | wmask;
                IDX_DOUT_CLR: cfg_d.dout   = cfg_q.dout & ~wmask;
                IDX_OE:       cfg_d.oe     = wmask;
                IDX_OE_SET:   cfg_d.oe     = cfg_q.oe | wmask;
                IDX_OE_CLR:   cfg_d.oe     = cfg_q.oe & ~wmask;
                IDX_OTYPE:    cfg_d.otype  = wmask;
                IDX_POL:      cfg_d.pol    = wmask;
                IDX_PULLUP:   cfg_d.pu     = wmask;
                IDX_PULLDN:   cfg_d.pd     = wmask;
                IDX_INEN:     cfg_d.inen   = wmask;
                IDX_EVMODE:   cfg_d.evmode = wmask;
                IDX_EVBOTH:   cfg_d.evboth = wmask;
                IDX_EVEN:     cfg_d.even   = wmask;
                IDX_EVEN_SET: cfg_d.even   = cfg_q.even | wmask;
                IDX_EVEN_CLR: cfg_d.even   = cfg_q.even & ~wmask;
                default:      cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.pu   <= '1;
            cfg_q.inen <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    gpio_pin_resolve #(.NPINS(NPINS)) u_resolve (
        .dout  (cfg_q.dout),
        .pol   (cfg_q.pol),
        .oe    (cfg_q.oe),
        .otype (cfg_q.otype),
        .pu    (cfg_q.pu),
        .pd    (cfg_q.pd),
        .inen  (cfg_q.inen),
        .pad   (pad_in),
        .pin   (pin_level),
        .din   (din)
    );

    gpio_event_unit #(.NPINS(NPINS)) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .edge_sel (cfg_q.evmode),
        .both_sel (cfg_q.evboth),
        .clr_en   (clr_en),
        .clr_mask (wmask),
        .status   (status)
    );

    gpio_lock_unit #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_a     (wr_a),
        .wr_b     (wr_b),
        .wr_other (wr_other),
        .wdata    (bus_wdata),
        .locked   (locked)
    );

    assign irq = |(status & cfg_q.even);

    always_comb begin
        logic [NPINS-1:0] fld;
        case (idx)
            IDX_DOUT:   fld = cfg_q.dout;
            IDX_OE:     fld = cfg_q.oe;
            IDX_OTYPE:  fld = cfg_q.otype;
            IDX_POL:    fld = cfg_q.pol;
            IDX_PULLUP: fld = cfg_q.pu;
            IDX_PULLDN: fld = cfg_q.pd;
            IDX_INEN:   fld = cfg_q.inen;
            IDX_DIN:    fld = din;
            IDX_EVMODE: fld = cfg_q.evmode;
            IDX_EVBOTH: fld = cfg_q.evboth;
            IDX_EVEN:   fld = cfg_q.even;
            IDX_EVSTAT: fld = status;
            default:    fld = '0;
        endcase
        bus_rdata = '0;
        bus_rdata[NPINS-1:0] = fld;
        if (idx == IDX_LOCK_A) begin
            bus_rdata[0] = locked;
        end
    end

    // R9: while locked, data-out holds
    a_r9_dout_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(cfg_q.dout));

    // R2: an enabled push-pull pin carries data-out XOR polarity
    a_r2_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_level ^ cfg_q.dout ^ cfg_q.pol) & cfg_q.oe & ~cfg_q.otype) == '0);

    // R5: an open-drain pin driving low reads low
    a_r5_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level & cfg_q.oe & cfg_q.otype & ~(cfg_q.dout ^ cfg_q.pol)) == '0);

    // R13: the interrupt only drops after a status clear or an enable change
    a_r13_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && (idx == IDX_EVSTAT || idx == IDX_EVEN || idx == IDX_EVEN_CLR)))
        |=> irq);

endmodule

// File: tb/gpio_lockctl_test.sv
module gpio_lockctl_test;

    localparam int CLK_P = 10;
    localparam int NP    = 8;
    localparam logic [31:0] KA = 32'h4F1D_0B7C;
    localparam logic [31:0] KB = 32'h9A3C_5EED;

    localparam logic [4:0] A_DOUT = 0, A_DSET = 1, A_DCLR = 2, A_OE = 3,
        A_OSET = 4, A_OCLR = 5, A_OTYP = 6, A_POL = 7, A_PU = 8, A_PD = 9,
        A_INEN = 10, A_DIN = 11, A_EVM = 12, A_EVB = 13, A_EVEN = 14,
        A_ESET = 15, A_ECLR = 16, A_STAT = 17, A_LKA = 18, A_LKB = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pin_level;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_lockctl #(.NPINS(NP), .KEY_A(KA), .KEY_B(KB)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pin_level(pin_level), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic model_pin(logic oe, logic ot, logic dv, logic pl,
                                       logic pu, logic pd, logic pad);
        logic lvl;
        lvl = dv ^ pl;
        if (oe && (!ot || !lvl)) return lvl;
        if (pu != pd) return pu;
        return pad;
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(A_DOUT, r); chk("R1 dout", r, 0);
        rd(A_PU, r);   chk("R1 pull-up", r, 32'hFF);
        rd(A_INEN, r); chk("R1 input enable", r, 32'hFF);
        rd(A_PD, r);   chk("R1 pull-down", r, 0);
        rd(A_EVEN, r); chk("R1 event enable", r, 0);
        rd(A_LKA, r);  chk("R1 lock open", r, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        // R10: pulled-up pins read high and level events latch
        rd(A_STAT, r); chk("R10 status after reset", r, 32'hFF);

        // R2 R3 R4 R5 R6 exhaustive sweep, one combination per pin
        for (int b = 0; b < 32; b++) begin
            logic [NP-1:0] v_oe, v_ot, v_dv, v_pl, v_pu, v_pd, v_ie, v_pad, e_pin, e_din;
            for (int p = 0; p < NP; p++) begin
                logic [7:0] c;
                c = 8'(b * NP + p);
                v_oe[p] = c[0]; v_ot[p] = c[1]; v_dv[p] = c[2]; v_pl[p] = c[3];
                v_pu[p] = c[4]; v_pd[p] = c[5]; v_ie[p] = c[6]; v_pad[p] = c[7];
                e_pin[p] = model_pin(c[0], c[1], c[2], c[3], c[4], c[5], c[7]);
                e_din[p] = (c[6] & e_pin[p]) ^ c[3];
            end
            wr(A_OE, 32'(v_oe));  wr(A_OTYP, 32'(v_ot)); wr(A_DOUT, 32'(v_dv));
            wr(A_POL, 32'(v_pl)); wr(A_PU, 32'(v_pu));   wr(A_PD, 32'(v_pd));
            wr(A_INEN, 32'(v_ie));
            pad_in = v_pad;
            rd(A_DIN, r);
            chk("R2 R3 R4 R5 R6 sweep din", r, 32'(e_din));
            chk("R2 R3 R4 R5 R6 sweep pin", 32'(pin_level), 32'(e_pin));
        end

        // directed resolution cases
        pad_in = 8'hA5;
        wr(A_INEN, 32'hFF); wr(A_POL, 0); wr(A_OTYP, 0);
        wr(A_OE, 32'hFF); wr(A_PU, 32'hF0); wr(A_PD, 32'h0F); wr(A_DOUT, 32'h5C);
        rd(A_DIN, r); chk("R2 push-pull ignores pulls", r, 32'h5C);
        wr(A_OE, 0);
        rd(A_DIN, r); chk("R3 pulls decide", r, 32'hF0);
        wr(A_PD, 32'hF0);
        chk("R4 pad decides", 32'(pin_level), 32'hA5);
        wr(A_PD, 32'h0F); wr(A_OTYP, 32'hFF);
        rd(A_DIN, r); chk("R5 drive type ignored when disabled", r, 32'hF0);
        wr(A_OE, 32'hFF);
        rd(A_DIN, r); chk("R5 open drain", r, 32'h50);
        wr(A_OTYP, 0); wr(A_POL, 32'h33); wr(A_INEN, 32'h0F);
        rd(A_DIN, r); chk("R6 masked reads polarity", r, 32'h3C);
        wr(A_POL, 0); wr(A_INEN, 32'hFF);

        // R7 aliases
        wr(A_DOUT, 32'h0F); wr(A_DSET, 32'h30); rd(A_DOUT, r); chk("R7 dout set", r, 32'h3F);
        wr(A_DCLR, 32'h05); rd(A_DOUT, r); chk("R7 dout clear", r, 32'h3A);
        wr(A_OE, 32'h81); wr(A_OSET, 32'h06); rd(A_OE, r); chk("R7 oe set", r, 32'h87);
        wr(A_OCLR, 32'h80); rd(A_OE, r); chk("R7 oe clear", r, 32'h07);
        wr(A_ESET, 32'h12); wr(A_ECLR, 32'h02); rd(A_EVEN, r); chk("R7 even set clear", r, 32'h10);
        wr(A_EVEN, 0);

        // R8 R9 lock
        wr(A_DOUT, 32'h11); wr(A_LKA, 0);
        rd(A_LKA, r); chk("R8 lock by word A", r, 1);
        wr(A_DOUT, 32'h22); wr(A_DSET, 32'hFF);
        rd(A_DOUT, r); chk("R9 dout frozen", r, 32'h11);
        wr(A_LKB, KB); wr(A_POL, 32'hFF); wr(A_LKA, KA);
        rd(A_LKA, r); chk("R8 broken sequence stays locked", r, 1);
        rd(A_POL, r); chk("R9 polarity frozen", r, 0);
        wr(A_LKB, KB); wr(A_LKA, KA);
        rd(A_LKA, r); chk("R8 unlock", r, 0);
        wr(A_DOUT, 32'h22); rd(A_DOUT, r); chk("R8 writes after unlock", r, 32'h22);
        wr(A_LKB, 32'h1234); rd(A_LKA, r); chk("R8 lock by word B", r, 1);
        wr(A_LKB, KB); wr(A_LKA, KA);

        // R10 R12 level events
        wr(A_OE, 32'hFF); wr(A_OTYP, 0); wr(A_EVM, 0); wr(A_DOUT, 32'h5A); idle(1);
        wr(A_STAT, 32'hFF); rd(A_STAT, r); chk("R10 level refills", r, 32'h5A);
        wr(A_DOUT, 0); idle(1);
        rd(A_STAT, r); chk("R12 sticky after drop", r, 32'h5A);
        wr(A_STAT, 32'h0A); rd(A_STAT, r); chk("R12 partial clear", r, 32'h50);
        wr(A_STAT, 32'h50); rd(A_STAT, r); chk("R12 full clear", r, 0);

        // R11 edge events
        wr(A_EVM, 32'hFF); wr(A_EVB, 0); wr(A_DOUT, 32'h0F); idle(1);
        wr(A_STAT, 32'hFF); idle(1);
        rd(A_STAT, r); chk("R11 steady no event", r, 0);
        wr(A_DOUT, 32'h3C); idle(1);
        rd(A_STAT, r); chk("R11 rising only", r, 32'h30);
        wr(A_DOUT, 32'hC3); idle(1);
        rd(A_STAT, r); chk("R11 rising accumulates", r, 32'hF3);
        wr(A_STAT, 32'hFF); wr(A_EVB, 32'hFF); wr(A_DOUT, 32'h3C); idle(1);
        rd(A_STAT, r); chk("R11 both edges", r, 32'hFF);
        wr(A_STAT, 32'hFF); wr(A_DOUT, 32'h38); idle(1);
        rd(A_STAT, r); chk("R11 single falling", r, 32'h04);

        // R13 interrupt
        chk("R13 masked", {31'b0, irq}, 0);
        wr(A_ESET, 32'h04); chk("R13 enable raises", {31'b0, irq}, 1);
        wr(A_ECLR, 32'h04); chk("R13 disable lowers", {31'b0, irq}, 0);
        wr(A_ESET, 32'h04);
        wr(A_EVM, 0); wr(A_DCLR, 32'h08); idle(1);
        chk("R13 held while status held", {31'b0, irq}, 1);
        rd(A_STAT, r); chk("R10 level plus held edge", r, 32'h3C);
        wr(A_STAT, 32'h04); chk("R13 clear lowers", {31'b0, irq}, 0);
        rd(A_STAT, r); chk("R12 clear one bit", r, 32'h38);
        wr(A_STAT, 32'h20); rd(A_STAT, r); chk("R10 still high re-sets", r, 32'h38);

        // R9 status clear works while locked, enable does not change
        wr(A_LKA, 0);
        wr(A_STAT, 32'h08); rd(A_STAT, r); chk("R9 clear while locked", r, 32'h30);
        wr(A_ESET, 32'h10);
        chk("R9 enable frozen irq", {31'b0, irq}, 0);
        rd(A_EVEN, r); chk("R9 enable frozen", r, 32'h04);
        wr(A_LKB, KB); wr(A_LKA, KA);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule